// File: doc/BRIEF.md
# Configuration Load Controller

This block brings a small volatile configuration memory up from a bitstream and then releases the rest of the chip in a fixed start-up order. A load begins after power-on reset, or after the active-low program request is released. Each load first wipes every memory word. It then samples the mode inputs once. These pick whether the block drives the configuration clock itself or follows an external one, and whether the data port is serial or parallel. With a parallel port, the block works out the 8-bit or 16-bit width from a detection pattern at the head of the stream.

The block ignores everything on the port until it sees the synchronisation word. The first word after sync must carry the expected device code. The second word gives the number of configuration words that follow. Those words are stored from address zero upward. The last word of the stream holds a CRC over the device code, the count and the data words.

When the CRC matches, the start-up sequence runs:
1. The internal flip-flop reset is released.
2. The block waits for clock lock, if that option was selected.
3. The output drivers are enabled.
4. DONE rises.

A device-code or CRC failure raises an error flag. DONE then stays low and the drivers stay off until a new program request arrives.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high, or while `prog_n` is low, `done`, `io_en` and `error` are low and `ff_reset` is high from the next clock on. A new load begins once both are inactive.
- R2: Every load first writes zero to all memory words, so any address a later, shorter load does not write reads back as 0.
- R3: After the clear, `mode_master`, `mode_par` and `mode_lockwait` are sampled exactly once. Changing them later in the same load has no effect.
- R4: In master mode the block toggles `cclk_out` while loading and takes a beat at each clock where `cclk_out` is high. In slave mode `cclk_out` stays low and a beat is taken at each rising edge of `cclk_in`.
- R5: A serial port takes one bit per beat on `din[0]`. A parallel port detects its width from the pattern bytes 0xBB then 0x11: if the beat after the one with low byte 0xBB equals 0x1122, the port is 16 bits wide; if only its low byte is 0x11, the port is 8 bits wide on `din[7:0]`. Words are assembled most significant part first.
- R6: Beats before the sync word 0xAA995566 are ignored.
- R7: The first word after sync must equal the `DEVICE_ID` parameter. Otherwise `error` rises one clock after that word completes.
- R8: The second word is a count N. The next N words are stored at addresses 0 to N-1. Words whose address is `DEPTH` or higher are not stored but still enter the CRC.
- R9: The final word must equal the CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, message bits taken most significant first, no final inversion) of the device code, the count and the N data words. A mismatch raises `error`.
- R10: On a CRC match, `ff_reset` falls one clock after the final word completes. Without a lock wait, `io_en` rises one clock after that and `done` rises one clock after `io_en`.
- R11: With the lock wait selected, `io_en` rises only one clock after a cycle in which `lock_in` is high, and `ff_reset` is already low during the wait.
- R12: After an error, `error` stays high and `done` and `io_en` stay low until `prog_n` goes low. A following load can then succeed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| prog_n | input | 1 | Program request, active low |
| mode_master | input | 1 | 1 = block drives the configuration clock |
| mode_par | input | 1 | 1 = parallel port, 0 = serial |
| mode_lockwait | input | 1 | 1 = wait for `lock_in` during start-up |
| cclk_in | input | 1 | External configuration clock (slave mode) |
| cclk_out | output | 1 | Generated configuration clock (master mode) |
| din | input | 16 | Configuration data port |
| lock_in | input | 1 | Clock-lock indication |
| rd_addr | input | AW | Memory read address |
| rd_data | output | 32 | Memory read data |
| ff_reset | output | 1 | Internal flip-flop reset, active high |
| io_en | output | 1 | Output driver enable |
| done | output | 1 | Configuration complete |
| error | output | 1 | Device-code or CRC failure |

## Verification
A sweep covers all twelve combinations of clock source, port kind (serial, 8-bit, 16-bit) and lock wait. It separates the width decision, the bit order within a word and the clock-source logic, because any slip in these breaks either the stored words or the CRC. Each stream carries junk ahead of the sync word, which exposes sync matching on pre-sync data. Further streams cover a wrong device code, a corrupted CRC, a shorter reload over a full memory, and a count larger than the memory. Together these separate the error paths, the clear and the bound on stores. A load with the mode pins flipped after sampling shows whether the mode is latched or followed.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    localparam logic [31:0] SYNC_WORD = 32'hAA99_5566;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam logic [7:0]  WPAT_MARK = 8'hBB;
    localparam logic [7:0]  WPAT_NARROW = 8'h11;
    localparam logic [15:0] WPAT_WIDE = 16'h1122;

    typedef enum logic [1:0] {PW_BIT, PW_BYTE, PW_HALF} port_w_e;

    typedef enum logic [3:0] {
        S_HOLD, S_CLEAR, S_MODE, S_WIDTH, S_HUNT, S_LOAD,
        S_REL, S_LOCK, S_IO, S_DONE, S_ERR
    } ld_state_e;

    typedef struct packed {
        logic master;
        logic par;
        logic lockw;
    } mode_t;

    // one 32-bit word folded into the running CRC, MSB first
    function automatic logic [31:0] crc32_word(logic [31:0] c, logic [31:0] w);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            fb = r[31] ^ w[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic logic [4:0] last_beat(port_w_e pw);
        case (pw)
            PW_BYTE: return 5'd3;
            PW_HALF: return 5'd1;
            default: return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/cfg_beat_gen.sv
module cfg_beat_gen (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic master,
    input  logic cclk_in,
    output logic beat,
    output logic cclk_out
);
    logic tog;
    logic cin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog   <= 1'b0;
            cin_q <= 1'b0;
        end else begin
            cin_q <= cclk_in;
            tog   <= (run && master) ? ~tog : 1'b0;
        end
    end

    assign cclk_out = tog;
    assign beat     = run && (master ? tog : (cclk_in && !cin_q));
endmodule

// File: rtl/cfg_word_asm.sv
module cfg_word_asm
    import cfg_load_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        beat,
    input  logic        count_en,
    input  port_w_e     pw,
    input  logic [15:0] din,
    output logic [31:0] sr_nxt,
    output logic        word_done
);
    logic [31:0] sr;
    logic [4:0]  bcnt;
    logic [4:0]  last;

    assign last = last_beat(pw);

    always_comb begin
        case (pw)
            PW_BYTE: sr_nxt = {sr[23:0], din[7:0]};
            PW_HALF: sr_nxt = {sr[15:0], din};
            default: sr_nxt = {sr[30:0], din[0]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            bcnt <= '0;
        end else begin
            if (beat) sr <= sr_nxt;
            if (!count_en)  bcnt <= '0;
            else if (beat)  bcnt <= (bcnt == last) ? 5'd0 : bcnt + 5'd1;
        end
    end

    assign word_done = beat && count_en && (bcnt == last);
endmodule

// File: rtl/cfg_mem.sv
module cfg_mem #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_load_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter logic [31:0] DEVICE_ID = 32'h0A5C_3D71,
    localparam int         AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_n,
    input  logic          mode_master,
    input  logic          mode_par,
    input  logic          mode_lockwait,
    input  logic          cclk_in,
    output logic          cclk_out,
    input  logic [15:0]   din,
    input  logic          lock_in,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          ff_reset,
    output logic          io_en,
    output logic          done,
    output logic          error
);
    ld_state_e     state;
    mode_t         mode_q;
    port_w_e       pw_q;
    logic [AW-1:0] clr_addr;
    logic          bb_seen;
    logic [31:0]   widx;
    logic [31:0]   nwords;
    logic [31:0]   crc;
    logic [31:0]   data_idx;
    logic [31:0]   word;
    logic          beat;
    logic          word_done;
    logic          run;
    logic          store;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;

    assign run = (state == S_WIDTH) || (state == S_HUNT) || (state == S_LOAD);

    cfg_beat_gen beat_i (
        .clk(clk), .rst(rst), .run(run), .master(mode_q.master),
        .cclk_in(cclk_in), .beat(beat), .cclk_out(cclk_out)
    );

    cfg_word_asm asm_i (
        .clk(clk), .rst(rst), .beat(beat), .count_en(state == S_LOAD),
        .pw(pw_q), .din(din), .sr_nxt(word), .word_done(word_done)
    );

    assign data_idx = widx - 32'd2;
    assign store    = (state == S_LOAD) && word_done && (widx >= 32'd2)
                    && (widx < nwords + 32'd2) && (data_idx < 32'(DEPTH));
    assign mem_we    = (state == S_CLEAR) || store;
    assign mem_addr  = (state == S_CLEAR) ? clr_addr : data_idx[AW-1:0];
    assign mem_wdata = (state == S_CLEAR) ? 32'd0 : word;

    cfg_mem #(.DEPTH(DEPTH)) mem_i (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_CLEAR;
            clr_addr <= '0;
            mode_q   <= '0;
            pw_q     <= PW_BIT;
            bb_seen  <= 1'b0;
            widx     <= '0;
            nwords   <= '0;
            crc      <= CRC_SEED;
        end else if (!prog_n) begin
            state    <= S_HOLD;
            clr_addr <= '0;
        end else begin
            case (state)
                S_HOLD: state <= S_CLEAR;
                S_CLEAR: begin
                    clr_addr <= clr_addr + 1'b1;
                    if (clr_addr == AW'(DEPTH - 1)) state <= S_MODE;
                end
                S_MODE: begin
                    mode_q  <= '{master: mode_master, par: mode_par, lockw: mode_lockwait};
                    pw_q    <= PW_BIT;
                    bb_seen <= 1'b0;
                    state   <= mode_par ? S_WIDTH : S_HUNT;
                end
                S_WIDTH: if (beat) begin
                    if (bb_seen && din == WPAT_WIDE) begin
                        pw_q  <= PW_HALF;
                        state <= S_HUNT;
                    end else if (bb_seen && din[7:0] == WPAT_NARROW) begin
                        pw_q  <= PW_BYTE;
                        state <= S_HUNT;
                    end else begin
                        bb_seen <= (din[7:0] == WPAT_MARK);
                    end
                end
                S_HUNT: if (beat && word == SYNC_WORD) begin
                    state <= S_LOAD;
                    widx  <= '0;
                    crc   <= CRC_SEED;
                end
                S_LOAD: if (word_done) begin
                    if (widx < nwords + 32'd2 || widx < 32'd2) begin
                        crc  <= crc32_word(crc, word);
                        widx <= widx + 32'd1;
                        if (widx == 32'd1) nwords <= word;
                        if (widx == 32'd0 && word != DEVICE_ID) state <= S_ERR;
                    end else begin
                        state <= (word == crc) ? S_REL : S_ERR;
                    end
                end
                S_REL:  state <= mode_q.lockw ? S_LOCK : S_IO;
                S_LOCK: if (lock_in) state <= S_IO;
                S_IO:   state <= S_DONE;
                default: state <= state;
            endcase
        end
    end

    assign ff_reset = !((state == S_REL) || (state == S_LOCK) || (state == S_IO) || (state == S_DONE));
    assign io_en    = (state == S_IO) || (state == S_DONE);
    assign done     = (state == S_DONE);
    assign error    = (state == S_ERR);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic clk,
    input logic rst,
    input logic prog_n,
    input logic lock_in,
    input logic cclk_out,
    input logic ff_reset,
    input logic io_en,
    input logic done,
    input logic error,
    input logic lockw_q,
    input logic master_q
);
    // R1
    prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_n |=> (!done && !io_en && !error && ff_reset));

    // R4
    slave_clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !master_q |-> !cclk_out);

    // R10
    io_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_en) |-> $past(!ff_reset));

    // R10
    done_after_io_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(io_en));

    // R10
    done_state_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (io_en && !ff_reset));

    // R11
    lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(io_en) && lockw_q) |-> $past(lock_in));

    // R12
    error_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (!done && !io_en && ff_reset));

    // R12
    error_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (error && prog_n) |=> error);
endmodule

bind cfg_loader cfg_loader_chk chk_i (
    .clk(clk), .rst(rst), .prog_n(prog_n), .lock_in(lock_in),
    .cclk_out(cclk_out), .ff_reset(ff_reset), .io_en(io_en),
    .done(done), .error(error), .lockw_q(mode_q.lockw), .master_q(mode_q.master)
);

// File: tb/cfg_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_loader_tb_top;
    localparam int          DEPTH = 8;
    localparam int          AW    = $clog2(DEPTH);
    localparam logic [31:0] DEV   = 32'h0A5C_3D71;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_n = 1'b1;
    logic          mode_master = 1'b0, mode_par = 1'b0, mode_lockwait = 1'b0;
    logic          cclk_in = 1'b0;
    logic          cclk_out;
    logic [15:0]   din = '0;
    logic          lock_in = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          ff_reset, io_en, done, error;

    int  n_run = 0;
    int  n_fail = 0;
    bit  is_master = 1'b0;
    bit  saw_tog = 1'b0;
    logic [31:0] dw [DEPTH + 2];

    always #2.5 clk = ~clk;

    cfg_loader #(.DEPTH(DEPTH), .DEVICE_ID(DEV)) dut_i (
        .clk(clk), .rst(rst), .prog_n(prog_n), .mode_master(mode_master),
        .mode_par(mode_par), .mode_lockwait(mode_lockwait), .cclk_in(cclk_in),
        .cclk_out(cclk_out), .din(din), .lock_in(lock_in), .rd_addr(rd_addr),
        .rd_data(rd_data), .ff_reset(ff_reset), .io_en(io_en), .done(done),
        .error(error)
    );

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] w);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--)
            r = (r << 1) ^ (((r[31] ^ w[i]) != 1'b0) ? 32'h04C1_1DB7 : 32'h0);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_beat(input logic [15:0] v);
        din = v;
        if (is_master) begin
            do @(negedge clk); while (!cclk_out);
            saw_tog = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end else begin
            @(negedge clk); cclk_in = 1'b1;
            @(negedge clk); cclk_in = 1'b0;
        end
    endtask

    // p: 0 serial, 1 byte, 2 halfword
    task automatic send_word(input logic [31:0] w, input int p);
        if (p == 0)      for (int i = 31; i >= 0; i--) send_beat({15'd0, w[i]});
        else if (p == 1) for (int i = 3; i >= 0; i--)  send_beat({8'd0, w[i*8 +: 8]});
        else begin send_beat(w[31:16]); send_beat(w[15:0]); end
    endtask

    task automatic begin_load(input bit m, input bit par, input bit lk);
        lock_in = 1'b0;
        is_master = m;
        saw_tog = 1'b0;
        mode_master = m; mode_par = par; mode_lockwait = lk;
        @(negedge clk); prog_n = 1'b0;
        @(negedge clk);
        // R1: outputs quiet while program request is held
        chk(!done && !io_en && !error && ff_reset, "R1", {28'd0, done, io_en, error, ff_reset}, 32'h1);
        prog_n = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
    endtask

    task automatic send_head(input int p);
        send_word(32'h0000_00BB, p);
        send_word(32'h1122_0044, p);
        send_word(32'h1234_5678, p);   // junk before sync (R6)
        send_word(32'hAA99_5566, p);
    endtask

    task automatic send_body(input int p, input logic [31:0] id, input int n, input bit bad_crc, input logic [31:0] seed);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) dw[i] = 32'h9E37_79B9 * (i + 1) + seed;
        c = ref_crc(c, id);
        c = ref_crc(c, 32'(n));
        for (int i = 0; i < n; i++) c = ref_crc(c, dw[i]);
        send_word(id, p);
        send_word(32'(n), p);
        for (int i = 0; i < n; i++) send_word(dw[i], p);
        send_word(c ^ {31'd0, bad_crc}, p);
    endtask

    task automatic check_startup(input bit lk);
        chk(!ff_reset && !io_en && !done, "R10 release first", {29'd0, ff_reset, io_en, done}, 32'h0);
        if (lk) begin
            repeat (3) @(negedge clk);
            chk(!io_en && !ff_reset, "R11 waits for lock", {30'd0, io_en, ff_reset}, 32'h0);
            lock_in = 1'b1;
            @(negedge clk);
            chk(io_en && !done, "R11 io after lock", {30'd0, io_en, done}, 32'h2);
        end else begin
            @(negedge clk);
            chk(io_en && !done, "R10 io second", {30'd0, io_en, done}, 32'h2);
        end
        @(negedge clk);
        chk(done && !error, "R10 R9 done last", {30'd0, done, error}, 32'h2);
    endtask

    task automatic check_mem(input int n, input string req);
        for (int a = 0; a < DEPTH; a++) begin
            logic [31:0] e;
            rd_addr = AW'(a);
            #1;
            e = (a < n) ? dw[a] : 32'd0;
            chk(rd_data === e, req, rd_data, e);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !io_en && !error && ff_reset, "R1 reset state", {28'd0, done, io_en, error, ff_reset}, 32'h1);

        // sweep: clock source x port kind x lock wait (R4 R5 R6 R8)
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 3; p++)
                for (int lk = 0; lk < 2; lk++) begin
                    begin_load(m[0], p != 0, lk[0]);
                    send_head(p);
                    send_body(p, DEV, DEPTH, 1'b0, 32'(m * 16 + p * 4 + lk));
                    check_startup(lk[0]);
                    check_mem(DEPTH, "R8 R5 R6 stored word");
                    if (m == 0) chk(cclk_out == 1'b0, "R4 slave clock idle", {31'd0, cclk_out}, 32'h0);
                    else        chk(saw_tog, "R4 master clock toggles", {31'd0, saw_tog}, 32'h1);
                end

        // R2: shorter reload leaves cleared words at zero
        begin_load(1'b0, 1'b1, 1'b0);
        send_head(1);
        send_body(1, DEV, 3, 1'b0, 32'h55);
        check_startup(1'b0);
        check_mem(3, "R2 cleared word");

        // R8: count beyond memory depth, extra words only feed the CRC
        begin_load(1'b1, 1'b1, 1'b0);
        send_head(2);
        send_body(2, DEV, DEPTH + 2, 1'b0, 32'h77);
        check_startup(1'b0);
        check_mem(DEPTH, "R8 depth bound");

        // R3: mode pins flipped after sampling
        begin_load(1'b0, 1'b1, 1'b0);
        mode_master = 1'b1; mode_par = 1'b0; mode_lockwait = 1'b1;
        send_head(1);
        send_body(1, DEV, 4, 1'b0, 32'h99);
        check_startup(1'b0);
        chk(done, "R3 mode latched", {31'd0, done}, 32'h1);

        // R7: wrong device code
        begin_load(1'b0, 1'b1, 1'b0);
        send_head(1);
        send_word(DEV ^ 32'h1, 1);
        chk(error && !done && !io_en, "R7 bad device code", {29'd0, error, done, io_en}, 32'h4);

        // R12: error persists, then a new load succeeds
        repeat (6) @(negedge clk);
        chk(error && ff_reset, "R12 error held", {30'd0, error, ff_reset}, 32'h3);
        begin_load(1'b0, 1'b1, 1'b0);
        chk(!error, "R12 error cleared", {31'd0, error}, 32'h0);
        send_head(1);
        send_body(1, DEV, 2, 1'b1, 32'hAB);   // R9: corrupted CRC
        chk(error && !done && !io_en && ff_reset, "R9 CRC mismatch", {28'd0, error, done, io_en, ff_reset}, 32'h9);
        begin_load(1'b0, 1'b1, 1'b0);
        send_head(1);
        send_body(1, DEV, 2, 1'b0, 32'hAB);
        check_startup(1'b0);
        chk(done, "R12 recovery load", {31'd0, done}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule